// File: doc/BRIEF.md
# Receive-Only Two-Wire Command Target

This block listens on an I2C bus as a target that never sends data. It oversamples SCL and SDA with its own system clock, passes each line through a two-flop synchronizer and a glitch filter, and detects START and STOP conditions from the filtered samples. A transfer consists of a START, an address byte, four data bytes and a STOP. Each accepted byte is acknowledged by pulling SDA low during the ninth clock. The block never drives SDA at any other time.

The four data bytes form one 32-bit command word. The first byte received lands in bits 31..24, where a downstream decoder expects the function select (bits 31..28) and the multiplier (bits 27..24). The next three bytes fill bits 23..16, 15..8 and 7..0 of the value field. The word reaches the output, with a one-cycle valid pulse, only when a STOP closes a transfer that carried exactly four acknowledged data bytes. The following events discard the collected bytes without any output change:
- a START or repeated START that arrives before the STOP;
- an early STOP;
- a fifth byte.

The target address is 1100 0xx in binary. A two-bit strap input supplies the low two bits, so the strap selects an offset of 0 to 3 from the base 110 0000.

Top module: `i2cw_cmd_slave`

## Requirements
- R1: After reset the acknowledge drive is inactive, the valid pulse is low and the command word output is all zeros.
- R2: An address byte whose upper seven bits equal {11000, strap} and whose last bit (R/W) is 0 is acknowledged: SDA is held low while SCL is high in the ninth clock.
- R3: An address byte that does not match the strapped address, or that has R/W = 1, is not acknowledged. The block then ignores every following byte until the next START: it acknowledges none of them and commits nothing.
- R4: Each of the first four data bytes after a matching address is acknowledged. The first byte goes to word bits 31..24, the second to 23..16, the third to 15..8 and the fourth to 7..0.
- R5: The command word output changes only together with a one-cycle valid pulse, and that pulse follows the STOP that ends a complete four-byte transfer. Before that STOP, neither the output nor the pulse has changed.
- R6: A STOP that follows fewer than four data bytes produces no pulse and leaves the command word output unchanged.
- R7: A fifth data byte is not acknowledged, and the transfer is discarded: no pulse and no change of the command word output, even when a STOP follows.
- R8: A START or repeated START seen before the STOP purges the pending bytes. The transfer that the new START opens is handled from scratch.
- R9: A level on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. Such a pulse adds no bit and creates no false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 2 | Strap for the low two address bits |
| sda_pull_o | output | 1 | When high, the open-drain SDA driver pulls the line low |
| cmd_word_o | output | 32 | Last committed command word |
| cmd_valid_o | output | 1 | One-cycle pulse when a new word is committed |

## Verification
The address path is swept over every strap setting. For each setting the bench sends the four in-family addresses, an out-of-family address and both R/W values, which shows whether the strap bits, the fixed base bits and the direction bit are each decoded. Complete transfers sweep the strap against five function codes, with multiplier and value patterns that differ in every byte. A swapped or shifted byte lane, or a commit made before the STOP, therefore shows up in the committed word. Truncated transfers, over-long transfers and transfers interrupted by a repeated START are separated from good ones by the pulse count and by an unchanged word. A run with one-clock spikes on SCL and SDA in the middle of bytes separates a filtered front end from one that counts the spikes as bits or conditions.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int ADDR_W     = 7;
    localparam int ADDR_SEL_W = 2;
    localparam int BYTE_W     = 8;
    localparam int CMD_BYTES  = 4;
    localparam int WORD_W     = CMD_BYTES * BYTE_W;
    localparam int BC_W       = $clog2(CMD_BYTES + 1);
    localparam int BIT_W      = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_FULL,
        ST_IGNORE
    } rx_state_e;

    typedef enum logic [1:0] {
        AK_NONE,
        AK_PEND,
        AK_DRIVE
    } ack_state_e;

    typedef struct packed {
        rx_state_e          st;
        ack_state_e         ak;
        logic [BIT_W-1:0]   bit_cnt;
        logic [BC_W-1:0]    byte_cnt;
        logic [BYTE_W-1:0]  shreg;
        logic [WORD_W-1:0]  acc;
        logic [WORD_W-1:0]  word;
        logic               valid;
        logic               scl_p;
        logic               sda_p;
    } rx_regs_s;
endpackage

// File: rtl/i2cw_glitch_filter.sv
module i2cw_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } flt_s;

    localparam flt_s FLT_RST = '{sync: 2'b11, cnt: '0, out: 1'b1};

    flt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], raw_i};
        if (flt_q.sync[1] == flt_q.out) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.out = flt_q.sync[1];
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= FLT_RST;
        else        flt_q <= flt_d;
    end

    assign clean_o = flt_q.out;

    AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.out) |-> $past(flt_q.cnt) == CW'(FILT_LEN - 1)); // R9
endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
    import i2cw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_f,
    input  logic                  sda_f,
    input  logic [ADDR_SEL_W-1:0] addr_sel,
    output logic                  pull_low,
    output logic [WORD_W-1:0]     word,
    output logic                  valid
);
    localparam rx_regs_s RX_RST = '{st: ST_IDLE, ak: AK_NONE, bit_cnt: '0,
                                    byte_cnt: '0, shreg: '0, acc: '0,
                                    word: '0, valid: 1'b0,
                                    scl_p: 1'b1, sda_p: 1'b1};

    rx_regs_s rx_d, rx_q;

    logic scl_rise, scl_fall, start_c, stop_c;
    logic [BYTE_W-1:0] byte_v;
    logic [ADDR_W-1:0] my_addr;

    assign scl_rise = scl_f & ~rx_q.scl_p;
    assign scl_fall = ~scl_f & rx_q.scl_p;
    assign start_c  = scl_f & rx_q.scl_p & rx_q.sda_p & ~sda_f;
    assign stop_c   = scl_f & rx_q.scl_p & ~rx_q.sda_p & sda_f;
    assign byte_v   = {rx_q.shreg[BYTE_W-2:0], sda_f};
    assign my_addr  = {ADDR_BASE[ADDR_W-1:ADDR_SEL_W], addr_sel};

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.scl_p = scl_f;
        rx_d.sda_p = sda_f;
        if (start_c) begin
            rx_d.st       = ST_ADDR;
            rx_d.ak       = AK_NONE;
            rx_d.bit_cnt  = '0;
            rx_d.byte_cnt = '0;
        end else if (stop_c) begin
            if (rx_q.st == ST_FULL && rx_q.ak == AK_NONE) begin
                rx_d.valid = 1'b1;
                rx_d.word  = rx_q.acc;
            end
            rx_d.st = ST_IDLE;
            rx_d.ak = AK_NONE;
        end else if (rx_q.st == ST_ADDR || rx_q.st == ST_DATA || rx_q.st == ST_FULL) begin
            if (rx_q.ak == AK_PEND) begin
                if (scl_fall) rx_d.ak = AK_DRIVE;
            end else if (rx_q.ak == AK_DRIVE) begin
                if (scl_fall) rx_d.ak = AK_NONE;
            end else if (rx_q.st == ST_FULL) begin
                if (scl_fall) rx_d.st = ST_IGNORE;
            end else if (scl_rise) begin
                rx_d.shreg = byte_v;
                if (rx_q.bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    rx_d.bit_cnt = '0;
                    if (rx_q.st == ST_ADDR) begin
                        if (byte_v[BYTE_W-1:1] == my_addr && !byte_v[0]) begin
                            rx_d.ak = AK_PEND;
                            rx_d.st = ST_DATA;
                        end else begin
                            rx_d.st = ST_IGNORE;
                        end
                    end else begin
                        rx_d.acc      = {rx_q.acc[WORD_W-BYTE_W-1:0], byte_v};
                        rx_d.byte_cnt = rx_q.byte_cnt + 1'b1;
                        rx_d.ak       = AK_PEND;
                        if (rx_q.byte_cnt == BC_W'(CMD_BYTES - 1)) rx_d.st = ST_FULL;
                    end
                end else begin
                    rx_d.bit_cnt = rx_q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

    assign pull_low = (rx_q.ak == AK_DRIVE);
    assign word     = rx_q.word;
    assign valid    = rx_q.valid;

    AST_NO_ACK_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == ST_IGNORE || rx_q.st == ST_IDLE) |-> !pull_low); // R3
    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.byte_cnt <= BC_W'(CMD_BYTES)); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word)); // R5
    AST_COMMIT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(rx_q.st == ST_FULL)); // R6
endmodule

// File: rtl/i2cw_cmd_slave.sv
module i2cw_cmd_slave
    import i2cw_pkg::*;
#(
    parameter int                FILT_LEN  = 3,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [ADDR_SEL_W-1:0] addr_sel_i,
    output logic                  sda_pull_o,
    output logic [WORD_W-1:0]     cmd_word_o,
    output logic                  cmd_valid_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, clean_lines;
    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            i2cw_glitch_filter #(.FILT_LEN(FILT_LEN)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_lines[g]),
                .clean_o(clean_lines[g])
            );
        end
    endgenerate

    i2cw_rx_fsm #(.ADDR_BASE(ADDR_BASE)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (clean_lines[0]),
        .sda_f   (clean_lines[1]),
        .addr_sel(addr_sel_i),
        .pull_low(sda_pull_o),
        .word    (cmd_word_o),
        .valid   (cmd_valid_o)
    );
endmodule

// File: tb/sim_i2cw_cmd_slave.sv
module sim_i2cw_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 16;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic        pull;
    logic [31:0] cmd_word;
    logic        cmd_valid;
    logic        sda_bus;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] seen_word = 32'h0;

    assign sda_bus = sda_m & ~pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2cw_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(sel), .sda_pull_o(pull), .cmd_word_o(cmd_word),
        .cmd_valid_o(cmd_valid)
    );

    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            pulses++;
            seen_word = cmd_word;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
        tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            tick(HP / 2);
            if (glitch && i == 4) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; end
            tick(HP / 2);
            scl_m = 1'b1;
            tick(HP / 2);
            if (glitch && i == 2 && b[i]) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; end
            tick(HP / 2);
            scl_m = 1'b0;
            tick(2);
        end
        sda_m = 1'b1;
        tick(HP);
        scl_m = 1'b1;
        tick(HP / 2);
        acked = !sda_bus;
        tick(HP / 2);
        scl_m = 1'b0;
        tick(2);
    endtask

    // address byte then a number of data bytes taken from w (MSB first, then wraps)
    task automatic send_cmd(input logic [31:0] w, input int nbytes, input bit glitch,
                            input string req);
        bit ak;
        bus_start();
        send_byte({5'b11000, sel, 1'b0}, glitch, ak);
        check(ak, req, "address ack", {31'd0, ak}, 32'd1);
        for (int k = 0; k < nbytes; k++) begin
            send_byte(w[31 - 8 * (k % 4) -: 8], glitch, ak);
            check(ak == (k < 4), req, "data byte ack", {31'd0, ak}, {31'd0, k < 4});
        end
    endtask

    initial begin
        bit ak;
        int p0;
        logic [31:0] w;
        logic [31:0] last;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1
        check(pull == 1'b0, "R1", "reset pull", {31'd0, pull}, 32'd0);
        check(cmd_valid == 1'b0, "R1", "reset valid", {31'd0, cmd_valid}, 32'd0);
        check(cmd_word == 32'd0, "R1", "reset word", cmd_word, 32'd0);

        // R2 / R3: address decode sweep over strap, address and R/W
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            tick(4);
            for (int a = 0; a < 6; a++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    logic [6:0] addr;
                    bit exp_ack;
                    addr = (a < 4) ? 7'(7'h60 + a) : (a == 4 ? 7'h70 : 7'h20);
                    exp_ack = (addr == 7'(7'h60 + s)) && (rw == 0);
                    bus_start();
                    send_byte({addr, 1'(rw)}, 1'b0, ak);
                    check(ak == exp_ack, exp_ack ? "R2" : "R3", "address decode",
                          {31'd0, ak}, {31'd0, exp_ack});
                    bus_stop();
                end
            end
        end

        // R3: ignored after a rejected address, nothing commits
        sel = 2'd1;
        p0 = pulses;
        last = cmd_word;
        bus_start();
        send_byte(8'hC3, 1'b0, ak);
        check(!ak, "R3", "read request ack", {31'd0, ak}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h5A, 1'b0, ak);
            check(!ak, "R3", "ignored byte ack", {31'd0, ak}, 32'd0);
        end
        bus_stop();
        check(pulses == p0, "R3", "pulse after ignore", 32'(pulses), 32'(p0));
        check(cmd_word == last, "R3", "word after ignore", cmd_word, last);

        // R4 / R5: complete transfers across strap and function code
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            for (int fs = 0; fs < 5; fs++) begin
                w = {4'(fs), 4'(s + 3 * fs), 24'((fs * 24'h135791 + s * 24'h2468AC + 24'h0F1E2D) & 24'hFFFFFF)};
                p0 = pulses;
                last = cmd_word;
                send_cmd(w, 4, 1'b0, "R4");
                tick(HP);
                check(pulses == p0, "R5", "no pulse before stop", 32'(pulses), 32'(p0));
                check(cmd_word == last, "R5", "word before stop", cmd_word, last);
                bus_stop();
                check(pulses == p0 + 1, "R5", "one pulse on stop", 32'(pulses), 32'(p0 + 1));
                check(seen_word == w, "R4", "committed word", seen_word, w);
                check(cmd_word == w, "R5", "held word", cmd_word, w);
            end
        end

        // R6: short transfers
        sel = 2'd2;
        for (int n = 0; n < 4; n++) begin
            p0 = pulses;
            last = cmd_word;
            send_cmd(32'hA1B2C3D4, n, 1'b0, "R6");
            bus_stop();
            check(pulses == p0, "R6", "short pulse", 32'(pulses), 32'(p0));
            check(cmd_word == last, "R6", "short word", cmd_word, last);
        end

        // R7: extra byte
        p0 = pulses;
        last = cmd_word;
        send_cmd(32'h3C4D5E6F, 5, 1'b0, "R7");
        bus_stop();
        check(pulses == p0, "R7", "extra byte pulse", 32'(pulses), 32'(p0));
        check(cmd_word == last, "R7", "extra byte word", cmd_word, last);

        // R8: repeated start purges partial and full pending data
        p0 = pulses;
        send_cmd(32'hDEADBEEF, 2, 1'b0, "R8");
        send_cmd(32'h21436587, 4, 1'b0, "R8");
        bus_stop();
        check(pulses == p0 + 1, "R8", "restart pulse count", 32'(pulses), 32'(p0 + 1));
        check(cmd_word == 32'h21436587, "R8", "restart word", cmd_word, 32'h21436587);
        p0 = pulses;
        send_cmd(32'h11223344, 4, 1'b0, "R8");
        bus_start();
        send_byte({5'b11000, sel, 1'b0}, 1'b0, ak);
        bus_stop();
        check(pulses == p0, "R8", "purged full pulse", 32'(pulses), 32'(p0));
        check(cmd_word == 32'h21436587, "R8", "purged full word", cmd_word, 32'h21436587);

        // R9: one-clock spikes on both lines
        sel = 2'd3;
        p0 = pulses;
        w = 32'h47F6E5D4;
        send_cmd(w, 4, 1'b1, "R9");
        bus_stop();
        check(pulses == p0 + 1, "R9", "glitch pulse count", 32'(pulses), 32'(p0 + 1));
        check(cmd_word == w, "R9", "glitch word", cmd_word, w);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule